// File: doc/BRIEF.md
# Numeric-Error Interrupt Handshake Controller

This block raises the legacy numeric-error interrupt line for a processor core whose floating-point unit has no dedicated error-report and error-ignore pins. It watches a native-error-mode control bit and the error-summary bit of the FPU status word. When native reporting is off and an error is pending, it raises the interrupt request.

Software acknowledges the interrupt by writing one byte to I/O port F0h or F1h. That write clears the request and tells the FPU to ignore numeric errors. Ignore mode holds until the error-summary bit falls. The controller then goes back to monitoring, and a later error can raise the request again.

Three states govern the behaviour: idle, asserted and ignoring. Both outputs are registered and change on the clock edge that samples their cause.

Top module: `numerr_irq_ctrl`

## Requirements
- R1: After reset, irqOut and ignoreErr are both 0.
- R2: Whenever nativeErrMode is 1 at a clock edge, irqOut is 0 after that edge.
- R3: From idle, with nativeErrMode 0 and errSummary 1 at an edge, irqOut is 1 after that edge.
- R4: An acknowledge is ioWrValid=1 with ioWrSize=0 (code 0 = one byte) and ioWrAddr equal to 00F0h or 00F1h. An acknowledge sampled while irqOut is 1 makes irqOut 0 and ignoreErr 1 after that edge. In that cycle it takes priority over nativeErrMode and errSummary.
- R5: A write to F0h/F1h with ioWrSize 1, 2 or 3 (16, 32 or 64 bits), or a byte write to any other address, does not acknowledge: irqOut stays 1 and ignoreErr stays 0.
- R6: An acknowledge sampled in idle has no effect: both outputs stay 0, and a later error still raises irqOut.
- R7: While ignoreErr is 1, irqOut stays 0 even with errSummary held at 1. Further acknowledges change nothing.
- R8: With ignoreErr at 1, errSummary 0 at an edge makes ignoreErr 0 after that edge. The block is then idle and can raise irqOut again by R3.
- R9: With irqOut at 1 and no acknowledge, errSummary 0 or nativeErrMode 1 at an edge makes irqOut 0 after that edge and returns to idle.
- R10: irqOut and ignoreErr are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nativeErrMode | input | 1 | 1 = errors reported natively, legacy interrupt suppressed |
| errSummary | input | 1 | FPU status word error-summary bit |
| ioWrValid | input | 1 | I/O write strobe |
| ioWrAddr | input | 16 | I/O write port address |
| ioWrSize | input | 2 | Write size code: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| irqOut | output | 1 | Legacy numeric-error interrupt request (active high) |
| ignoreErr | output | 1 | To FPU: ignore numeric errors |

## Verification
Every result is due exactly one clock after the inputs that cause it: the state register and both output registers update on the edge that samples the cause. The bench drives inputs on the falling edge. On the next rising edge it advances its own three-state model from those same inputs. It compares irqOut and ignoreErr on the following falling edge, before driving new stimulus. That puts every comparison one edge after its cause and away from the active edge.

// File: rtl/numerr_pkg.sv
package numerr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ASSERTED = 2'd1,
    ST_IGNORING = 2'd2
  } errState_e;

  typedef struct packed {
    logic setIrq;
    logic clrIrq;
    logic setIgn;
    logic clrIgn;
  } errStrobe_t;
endpackage

// File: rtl/numerr_ctrl.sv
module numerr_ctrl
  import numerr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       nativeErrMode,
  input  logic       errSummary,
  input  logic       ackHit,
  output errStrobe_t strobe
);
  errState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:
        if (!nativeErrMode && errSummary) stateD = ST_ASSERTED;
      ST_ASSERTED:
        if (ackHit)                            stateD = ST_IGNORING;
        else if (nativeErrMode || !errSummary) stateD = ST_IDLE;
      ST_IGNORING:
        if (!errSummary) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.setIrq = (stateQ != ST_ASSERTED) && (stateD == ST_ASSERTED);
    strobe.clrIrq = (stateQ == ST_ASSERTED) && (stateD != ST_ASSERTED);
    strobe.setIgn = (stateQ != ST_IGNORING) && (stateD == ST_IGNORING);
    strobe.clrIgn = (stateQ == ST_IGNORING) && (stateD != ST_IGNORING);
  end

  // R2
  native_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    nativeErrMode |=> (stateQ != ST_ASSERTED));

  // R3
  idle_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !nativeErrMode && errSummary) |=> (stateQ == ST_ASSERTED));

  // R9
  drop_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ASSERTED && !ackHit && (nativeErrMode || !errSummary)) |=> (stateQ == ST_IDLE));
endmodule

// File: rtl/numerr_dp.sv
module numerr_dp
  import numerr_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter int               SIZE_W    = 2,
  parameter logic [ADDR_W-1:0] ACK_PORT = 16'h00F0,
  parameter logic [SIZE_W-1:0] SIZE_BYTE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              errSummary,
  input  logic              ioWrValid,
  input  logic [ADDR_W-1:0] ioWrAddr,
  input  logic [SIZE_W-1:0] ioWrSize,
  input  errStrobe_t        strobe,
  output logic              ackHit,
  output logic              irqOut,
  output logic              ignoreErr
);
  localparam int PAIR_W = ADDR_W - 1;

  logic irqQ, ignQ;

  assign ackHit = ioWrValid && (ioWrSize == SIZE_BYTE) &&
                  (ioWrAddr[ADDR_W-1:1] == ACK_PORT[ADDR_W-1:1]) && (PAIR_W > 0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ <= 1'b0;
      ignQ <= 1'b0;
    end else begin
      if (strobe.setIrq)      irqQ <= 1'b1;
      else if (strobe.clrIrq) irqQ <= 1'b0;
      if (strobe.setIgn)      ignQ <= 1'b1;
      else if (strobe.clrIgn) ignQ <= 1'b0;
    end
  end

  assign irqOut    = irqQ;
  assign ignoreErr = ignQ;

  // R4
  ack_to_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && ackHit) |=> (!irqOut && ignoreErr));

  // R7
  no_reassert_chk: assert property (@(posedge clk) disable iff (!rstN)
    ignoreErr |=> !irqOut);

  // R8
  resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ignoreErr && !errSummary) |=> !ignoreErr);

  // R10
  exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(irqOut && ignoreErr));
endmodule

// File: rtl/numerr_irq_ctrl.sv
module numerr_irq_ctrl
  import numerr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nativeErrMode,
  input  logic              errSummary,
  input  logic              ioWrValid,
  input  logic [ADDR_W-1:0] ioWrAddr,
  input  logic [SIZE_W-1:0] ioWrSize,
  output logic              irqOut,
  output logic              ignoreErr
);
  errStrobe_t strobe;
  logic       ackHit;

  numerr_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .nativeErrMode (nativeErrMode),
    .errSummary    (errSummary),
    .ackHit        (ackHit),
    .strobe        (strobe)
  );

  numerr_dp #(
    .ADDR_W    (ADDR_W),
    .SIZE_W    (SIZE_W),
    .ACK_PORT  (ADDR_W'(16'h00F0)),
    .SIZE_BYTE ('0)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .errSummary (errSummary),
    .ioWrValid  (ioWrValid),
    .ioWrAddr   (ioWrAddr),
    .ioWrSize   (ioWrSize),
    .strobe     (strobe),
    .ackHit     (ackHit),
    .irqOut     (irqOut),
    .ignoreErr  (ignoreErr)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!irqOut && !ignoreErr));
endmodule

// File: tb/numerr_irq_ctrl_tb.sv
`timescale 1ns/1ps
module numerr_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        nativeErrMode = 1'b0;
  logic        errSummary = 1'b0;
  logic        ioWrValid = 1'b0;
  logic [15:0] ioWrAddr = '0;
  logic [1:0]  ioWrSize = '0;
  logic        irqOut, ignoreErr;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // bench model state: 0 idle, 1 asserted, 2 ignoring
  int mState = 0;
  string mTag = "R1";

  always #2.5 clk = ~clk;

  numerr_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .nativeErrMode(nativeErrMode), .errSummary(errSummary),
    .ioWrValid(ioWrValid), .ioWrAddr(ioWrAddr), .ioWrSize(ioWrSize),
    .irqOut(irqOut), .ignoreErr(ignoreErr)
  );

  function automatic bit isAck(bit v, logic [15:0] a, logic [1:0] s);
    return v && (s == 2'd0) && (a == 16'h00F0 || a == 16'h00F1);
  endfunction

  task automatic advance();
    bit ack;
    @(posedge clk);
    ack = isAck(ioWrValid, ioWrAddr, ioWrSize);
    if (!rstN) begin
      mState = 0; mTag = "R1";
    end else begin
      case (mState)
        0: if (!nativeErrMode && errSummary) begin mState = 1; mTag = "R3"; end
           else mTag = nativeErrMode ? "R2" : (ack ? "R6" : "R8");
        1: if (ack) begin mState = 2; mTag = "R4"; end
           else if (nativeErrMode || !errSummary) begin mState = 0; mTag = "R9"; end
           else mTag = "R5";
        default: if (!errSummary) begin mState = 0; mTag = "R8"; end
                 else mTag = "R7";
      endcase
    end
    @(negedge clk);
  endtask

  task automatic check();
    bit eIrq, eIgn;
    eIrq = (mState == 1);
    eIgn = (mState == 2);
    checks++;
    if (irqOut !== eIrq || ignoreErr !== eIgn) begin
      fails++;
      $display("FAIL %s: irqOut=%b ignoreErr=%b expected %b %b", mTag, irqOut, ignoreErr, eIrq, eIgn);
    end
    checks++;
    if (irqOut === 1'b1 && ignoreErr === 1'b1) begin
      fails++;
      $display("FAIL R10: irqOut=%b ignoreErr=%b expected not both 1", irqOut, ignoreErr);
    end
  endtask

  task automatic drive(bit nat, bit err, bit v, logic [15:0] a, logic [1:0] s);
    nativeErrMode = nat; errSummary = err; ioWrValid = v; ioWrAddr = a; ioWrSize = s;
  endtask

  task automatic cyc(bit nat, bit err, bit v, logic [15:0] a, logic [1:0] s);
    drive(nat, err, v, a, s);
    advance();
    check();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    @(negedge clk);
    advance(); advance();
    check();                                // R1 reset state
    rstN = 1'b1;
    // R2: native mode suppresses the request
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 16'h0, 2'd0);
    // R3: raise
    cyc(0, 1, 0, 16'h0, 2'd0);
    // R5: wrong size, wrong address
    cyc(0, 1, 1, 16'h00F0, 2'd1);
    cyc(0, 1, 1, 16'h00F1, 2'd3);
    cyc(0, 1, 1, 16'h00F2, 2'd0);
    // R4: byte ack at F1h
    cyc(0, 1, 1, 16'h00F1, 2'd0);
    // R7: ignoring holds, further acks change nothing
    cyc(0, 1, 1, 16'h00F0, 2'd0);
    cyc(0, 1, 0, 16'h0, 2'd0);
    // R8: error clears, resume
    cyc(0, 0, 0, 16'h0, 2'd0);
    cyc(0, 1, 0, 16'h0, 2'd0);              // R8 re-raise via R3
    // R9: error falls without ack
    cyc(0, 0, 0, 16'h0, 2'd0);
    // R6: ack while idle
    cyc(0, 0, 1, 16'h00F0, 2'd0);
    cyc(0, 1, 0, 16'h0, 2'd0);
    // R4 priority: ack together with native mode
    cyc(1, 1, 1, 16'h00F0, 2'd0);
    cyc(0, 0, 0, 16'h0, 2'd0);
    // R9: native mode drops an active request
    cyc(0, 1, 0, 16'h0, 2'd0);
    cyc(1, 1, 0, 16'h0, 2'd0);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit nat, err, v;
      logic [15:0] a;
      logic [1:0] s;
      nat = ($urandom_range(0, 9) == 0);
      err = ($urandom_range(0, 3) != 0);
      v   = ($urandom_range(0, 2) == 0);
      a   = ($urandom_range(0, 3) != 0) ? (16'h00F0 | 16'($urandom_range(0, 1)))
                                        : 16'($urandom_range(0, 16'hFFFF));
      s   = ($urandom_range(0, 3) != 0) ? 2'd0 : 2'($urandom_range(1, 3));
      cyc(nat, err, v, a, s);
    end
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end
endmodule